// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, every cycle, which of several hardware threads may fetch into a shared out-of-order core. For each thread it keeps a count of instructions in flight. A count rises by what the thread dispatches, and falls by what it retires and by what a squash removes. Fetch goes to the eligible thread holding the fewest in-flight instructions. When two or more eligible threads hold the same count, a rotating priority pointer breaks the tie.

A mode input sets how the shared instruction window is divided. In dynamic mode every thread may take any part of the window. In static mode each thread is held to an equal share of WINDOW/NTHREADS entries. A thread that has reached its share can no longer fetch, and any further dispatch it offers is clipped. Threads flagged as stalled never fetch. The total occupancy of the window is kept within its size. When the window is full, all dispatch is refused and a full flag is raised for the core.

Top module: `smt_fetch_sel`

## Requirements
- R1: After reset every count is zero, the rotating pointer is at thread 0 and win_full is low, so with no stalls sel_vld=1 and sel_tid=0.
- R2: When sel_vld is high, sel_tid is an eligible thread whose in-flight count is the lowest among the eligible threads.
- R3: Among eligible threads with equal lowest count, the one reached first when scanning upward (with wrap) from the pointer is chosen. After a cycle with sel_vld=1 the pointer becomes sel_tid+1 modulo NTHREADS. After a cycle with sel_vld=0 it is unchanged.
- R4: A thread whose stall bit (bit t of stall, for thread t) is set is never selected. If no thread is eligible, sel_vld is 0.
- R5: With static_mode=1, a thread whose count is at least WINDOW/NTHREADS is ineligible, and its accepted dispatch is clipped so that its count never exceeds that share.
- R6: With static_mode=0 no per-thread cap applies, so a thread with a count at or above WINDOW/NTHREADS stays eligible.
- R7: At each edge a thread's count becomes count + accepted dispatch − retire − squash, floored at zero. Squash and retire fields of thread t (field t of each bus, thread 0 in the lowest bits) affect only thread t.
- R8: The sum of all counts never exceeds WINDOW. Dispatch is granted in ascending thread order out of the free space present at the start of the cycle. win_full is 1 exactly when the sum equals WINDOW, and while it is 1 no dispatch is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| static_mode | input | 1 | 1: equal per-thread share cap; 0: fully shared window |
| stall | input | NTHREADS | Per-thread fetch stall, bit t for thread t |
| disp_cnt | input | NTHREADS*DW | Per-thread dispatch count this cycle, DW bits each |
| ret_cnt | input | NTHREADS*RW | Per-thread retire count this cycle, RW bits each |
| sq_cnt | input | NTHREADS*CW | Per-thread squash count this cycle, CW bits each |
| sel_tid | output | TW | Selected thread for fetch |
| sel_vld | output | 1 | A thread was selected |
| win_full | output | 1 | Window fully occupied; dispatch refused |

## Verification
The selection is combinational from the stall and mode inputs and from the registered counts and pointer. A change in stall or mode therefore shows up in the same cycle, while dispatch, retire and squash traffic changes the selection only in the cycle after the edge that takes it in. The bench drives each stimulus just after a falling edge and compares the outputs one nanosecond later. It then lets the rising edge commit the traffic and advances its own occupancy model at that same edge. Every expectation is thus sampled against the state in force between two rising edges.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic {
    SHARE_DYNAMIC = 1'b0,
    SHARE_STATIC  = 1'b1
  } share_mode_e;

  // Occupancy step: add, subtract, floor at zero, ceiling at lim.
  function automatic int unsigned occ_next(int unsigned cur, int unsigned add,
                                           int unsigned sub, int unsigned lim);
    int unsigned up;
    up = cur + add;
    if (up <= sub) return 0;
    up = up - sub;
    return (up > lim) ? lim : up;
  endfunction

  function automatic int unsigned umin(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // Room left under a cap, zero once the cap is reached.
  function automatic int unsigned headroom(int unsigned cur, int unsigned cap);
    return (cur >= cap) ? 0 : cap - cur;
  endfunction

  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/fts_occupancy.sv
module fts_occupancy
  import fts_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int WINDOW   = 32,
  parameter int DISP_MAX = 4,
  parameter int RET_MAX  = 4,
  localparam int CW = $clog2(WINDOW + 1),
  localparam int DW = $clog2(DISP_MAX + 1),
  localparam int RW = $clog2(RET_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   static_en,
  input  logic [NTHREADS*DW-1:0] disp_cnt,
  input  logic [NTHREADS*RW-1:0] ret_cnt,
  input  logic [NTHREADS*CW-1:0] sq_cnt,
  output logic [NTHREADS*CW-1:0] cnt_flat,
  output logic [CW-1:0]          occ_total,
  output logic                   win_full
);

  localparam int SHARE = WINDOW / NTHREADS;

  logic [CW-1:0] cnt_q [NTHREADS];
  logic [CW-1:0] grant [NTHREADS];
  logic [CW-1:0] total;
  share_mode_e   mode;

  assign mode = share_mode_e'(static_en);

  always_comb begin : sum_c
    int unsigned acc;
    acc = 0;
    for (int t = 0; t < NTHREADS; t++) acc = acc + 32'(cnt_q[t]);
    total = CW'(acc);
  end

  // Dispatch grants: ascending thread order out of the start-of-cycle free space.
  always_comb begin : grant_c
    int unsigned free_left;
    int unsigned room;
    int unsigned take;
    free_left = WINDOW - 32'(total);
    for (int t = 0; t < NTHREADS; t++) begin
      room = free_left;
      if (mode == SHARE_STATIC) room = umin(room, headroom(32'(cnt_q[t]), SHARE));
      take      = umin(32'(disp_cnt[t*DW +: DW]), room);
      grant[t]  = CW'(take);
      free_left = free_left - take;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHREADS; t++) cnt_q[t] <= '0;
    end else begin
      for (int t = 0; t < NTHREADS; t++)
        cnt_q[t] <= CW'(occ_next(32'(cnt_q[t]), 32'(grant[t]),
                                 32'(ret_cnt[t*RW +: RW]) + 32'(sq_cnt[t*CW +: CW]),
                                 WINDOW));
    end
  end

  always_comb begin
    for (int t = 0; t < NTHREADS; t++) cnt_flat[t*CW +: CW] = cnt_q[t];
  end

  assign occ_total = total;
  assign win_full  = (total == CW'(WINDOW));

endmodule

// File: rtl/fts_pick.sv
module fts_pick
  import fts_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int CW       = 6,
  parameter int SHARE    = 8,
  localparam int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic [NTHREADS*CW-1:0] cnt_flat,
  input  logic [NTHREADS-1:0]    stall,
  input  logic                   static_en,
  input  logic [TW-1:0]          ptr,
  output logic [NTHREADS-1:0]    elig,
  output logic [TW-1:0]          sel_tid,
  output logic                   sel_vld
);

  for (genvar g = 0; g < NTHREADS; g++) begin : g_elig
    assign elig[g] = !stall[g] &&
                     (share_mode_e'(static_en) == SHARE_DYNAMIC ||
                      cnt_flat[g*CW +: CW] < CW'(SHARE));
  end

  // Scan from the pointer; strict less-than keeps the first of equal counts.
  always_comb begin : scan_c
    int unsigned idx;
    int unsigned c;
    int unsigned best;
    int unsigned pick;
    logic        found;
    found = 1'b0;
    best  = 0;
    pick  = 0;
    for (int k = 0; k < NTHREADS; k++) begin
      idx = (32'(ptr) + k) % NTHREADS;
      c   = 32'(cnt_flat[idx*CW +: CW]);
      if (elig[idx] && (!found || c < best)) begin
        found = 1'b1;
        best  = c;
        pick  = idx;
      end
    end
    sel_tid = TW'(pick);
    sel_vld = found;
  end

endmodule

// File: rtl/smt_fetch_sel.sv
module smt_fetch_sel
  import fts_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int WINDOW   = 32,
  parameter int DISP_MAX = 4,
  parameter int RET_MAX  = 4,
  localparam int CW = $clog2(WINDOW + 1),
  localparam int DW = $clog2(DISP_MAX + 1),
  localparam int RW = $clog2(RET_MAX + 1),
  localparam int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   static_mode,
  input  logic [NTHREADS-1:0]    stall,
  input  logic [NTHREADS*DW-1:0] disp_cnt,
  input  logic [NTHREADS*RW-1:0] ret_cnt,
  input  logic [NTHREADS*CW-1:0] sq_cnt,
  output logic [TW-1:0]          sel_tid,
  output logic                   sel_vld,
  output logic                   win_full
);

  localparam int SHARE = WINDOW / NTHREADS;

  logic [NTHREADS*CW-1:0] cnt_flat;
  logic [CW-1:0]          occ_total;
  logic [NTHREADS-1:0]    elig;
  logic [TW-1:0]          rr_ptr;

  fts_occupancy #(
    .NTHREADS(NTHREADS), .WINDOW(WINDOW), .DISP_MAX(DISP_MAX), .RET_MAX(RET_MAX)
  ) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .static_en (static_mode),
    .disp_cnt  (disp_cnt),
    .ret_cnt   (ret_cnt),
    .sq_cnt    (sq_cnt),
    .cnt_flat  (cnt_flat),
    .occ_total (occ_total),
    .win_full  (win_full)
  );

  fts_pick #(
    .NTHREADS(NTHREADS), .CW(CW), .SHARE(SHARE)
  ) u_pick (
    .cnt_flat  (cnt_flat),
    .stall     (stall),
    .static_en (static_mode),
    .ptr       (rr_ptr),
    .elig      (elig),
    .sel_tid   (sel_tid),
    .sel_vld   (sel_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rr_ptr <= '0;
    else if (sel_vld) rr_ptr <= TW'(wrap_inc(32'(sel_tid), NTHREADS));
  end

endmodule

// File: rtl/smt_fetch_sel_chk.sv
module smt_fetch_sel_chk
  import fts_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int WINDOW   = 32,
  localparam int CW = $clog2(WINDOW + 1),
  localparam int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   static_mode,
  input logic [NTHREADS-1:0]    stall,
  input logic [NTHREADS-1:0]    elig,
  input logic [TW-1:0]          sel_tid,
  input logic                   sel_vld,
  input logic                   win_full,
  input logic [CW-1:0]          occ_total,
  input logic [NTHREADS*CW-1:0] cnt_flat,
  input logic [TW-1:0]          rr_ptr
);

  localparam int SHARE = WINDOW / NTHREADS;

  logic          armed;
  logic [CW-1:0] sel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign sel_cnt = cnt_flat[32'(sel_tid)*CW +: CW];

  a_r8_total_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ_total) <= WINDOW);

  a_r8_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    win_full |=> occ_total <= $past(occ_total));

  a_r4_stalled_never_picked: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |-> !stall[sel_tid]);

  a_r4_none_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> !sel_vld);

  a_r5_static_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (static_mode && sel_vld) |-> (32'(sel_cnt) < SHARE));

  a_r3_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sel_vld) |=> (32'(rr_ptr) == wrap_inc(32'($past(sel_tid)), NTHREADS)));

  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !sel_vld) |=> $stable(rr_ptr));

endmodule

bind smt_fetch_sel smt_fetch_sel_chk #(
  .NTHREADS(NTHREADS), .WINDOW(WINDOW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .static_mode (static_mode),
  .stall       (stall),
  .elig        (elig),
  .sel_tid     (sel_tid),
  .sel_vld     (sel_vld),
  .win_full    (win_full),
  .occ_total   (occ_total),
  .cnt_flat    (cnt_flat),
  .rr_ptr      (rr_ptr)
);

// File: tb/tb_smt_fetch_sel.sv
`timescale 1ns/1ps
module tb_smt_fetch_sel;

  localparam int NT    = 4;
  localparam int W     = 32;
  localparam int DMAX  = 4;
  localparam int RMAX  = 4;
  localparam int CW    = $clog2(W + 1);
  localparam int DW    = $clog2(DMAX + 1);
  localparam int RW    = $clog2(RMAX + 1);
  localparam int TW    = 2;
  localparam int SHARE = W / NT;

  // Table: thread t sits in nibble t of the 16-bit traffic words.
  localparam int NROWS = 9;
  localparam logic        TV_MODE  [NROWS] = '{0, 0, 0, 0, 0, 1, 0, 0, 0};
  localparam logic [3:0]  TV_STALL [NROWS] = '{4'h0, 4'h0, 4'h4, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0};
  localparam logic [15:0] TV_DISP  [NROWS] = '{16'h0004, 16'h0020, 16'h3000, 16'h0000, 16'h0400,
                                               16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [15:0] TV_RET   [NROWS] = '{16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h0000,
                                               16'h0000, 16'h0000, 16'h3103, 16'h0000};
  localparam logic [15:0] TV_SQ    [NROWS] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                               16'h0020, 16'h0000, 16'h0000, 16'h0000};
  localparam logic        TV_VLD   [NROWS] = '{1, 1, 1, 1, 0, 1, 1, 1, 1};
  localparam int          TV_ID    [NROWS] = '{0, 1, 3, 2, 0, 1, 1, 1, 3};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              static_mode;
  logic [NT-1:0]     stall;
  logic [NT*DW-1:0]  disp_cnt;
  logic [NT*RW-1:0]  ret_cnt;
  logic [NT*CW-1:0]  sq_cnt;
  logic [TW-1:0]     sel_tid;
  logic              sel_vld;
  logic              win_full;

  int   b_disp [NT];
  int   b_ret  [NT];
  int   b_sq   [NT];
  logic b_mode;
  logic [NT-1:0] b_stall;

  int m_cnt [NT];
  int m_ptr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  smt_fetch_sel #(.NTHREADS(NT), .WINDOW(W), .DISP_MAX(DMAX), .RET_MAX(RMAX)) dut (
    .clk(clk), .rst_n(rst_n), .static_mode(static_mode), .stall(stall),
    .disp_cnt(disp_cnt), .ret_cnt(ret_cnt), .sq_cnt(sq_cnt),
    .sel_tid(sel_tid), .sel_vld(sel_vld), .win_full(win_full)
  );

  always_comb begin
    static_mode = b_mode;
    stall       = b_stall;
    for (int t = 0; t < NT; t++) begin
      disp_cnt[t*DW +: DW] = DW'(b_disp[t]);
      ret_cnt[t*RW +: RW]  = RW'(b_ret[t]);
      sq_cnt[t*CW +: CW]   = CW'(b_sq[t]);
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int model_total();
    int s = 0;
    for (int t = 0; t < NT; t++) s += m_cnt[t];
    return s;
  endfunction

  // Lowest count among eligible threads first, then the earliest holder from the pointer.
  function automatic void model_sel(output bit v, output int id);
    int lo = W + 1;
    v = 0;
    id = 0;
    for (int t = 0; t < NT; t++)
      if (!b_stall[t] && !(b_mode && m_cnt[t] >= SHARE) && m_cnt[t] < lo) lo = m_cnt[t];
    for (int k = NT - 1; k >= 0; k--) begin
      int j = (m_ptr + k) % NT;
      if (!b_stall[j] && !(b_mode && m_cnt[j] >= SHARE) && m_cnt[j] == lo) begin
        v = 1;
        id = j;
      end
    end
  endfunction

  task automatic model_clock();
    bit v;
    int id;
    int free;
    model_sel(v, id);
    if (v) m_ptr = (id + 1) % NT;
    free = W - model_total();
    for (int t = 0; t < NT; t++) begin
      int g = b_disp[t];
      int n;
      if (g > free) g = free;
      if (b_mode && m_cnt[t] + g > SHARE) g = (m_cnt[t] >= SHARE) ? 0 : SHARE - m_cnt[t];
      free -= g;
      n = m_cnt[t] + g - b_ret[t] - b_sq[t];
      m_cnt[t] = (n < 0) ? 0 : n;
    end
  endtask

  task automatic load(input logic md, input logic [NT-1:0] st,
                      input logic [15:0] d, input logic [15:0] r, input logic [15:0] s);
    b_mode  = md;
    b_stall = st;
    for (int t = 0; t < NT; t++) begin
      b_disp[t] = int'(d[4*t +: 4]);
      b_ret[t]  = int'(r[4*t +: 4]);
      b_sq[t]   = int'(s[4*t +: 4]);
    end
  endtask

  task automatic clock_it();
    @(posedge clk);
    model_clock();
    @(negedge clk);
  endtask

  task automatic do_reset();
    load(1'b0, '0, 16'h0, 16'h0, 16'h0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < NT; t++) m_cnt[t] = 0;
    m_ptr = 0;
  endtask

  // Drive, check one nanosecond later, then commit on the rising edge.
  task automatic step(input logic md, input logic [NT-1:0] st,
                      input logic [15:0] d, input logic [15:0] r, input logic [15:0] s,
                      input int ev, input int eid, input int ef, input string tag);
    load(md, st, d, r, s);
    #1;
    if (ev >= 0) chk({tag, " sel_vld"}, int'(sel_vld), ev);
    if (ev == 1) chk({tag, " sel_tid"}, int'(sel_tid), eid);
    if (ef >= 0) chk({tag, " win_full"}, int'(win_full), ef);
    clock_it();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1: reset state
    #1;
    chk("R1 reset sel_vld", int'(sel_vld), 1);
    chk("R1 reset sel_tid", int'(sel_tid), 0);
    chk("R1 reset win_full", int'(win_full), 0);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int r = 0; r < NROWS; r++)
      step(TV_MODE[r], TV_STALL[r], TV_DISP[r], TV_RET[r], TV_SQ[r],
           int'(TV_VLD[r]), TV_ID[r], 0, $sformatf("R2 R3 R4 row %0d", r));

    // R5 static cap, then R6 same count in dynamic mode
    do_reset();
    step(1'b1, 4'hE, 16'h0004, 16'h0, 16'h0, 1, 0, -1, "R5 cap under share");
    step(1'b1, 4'hE, 16'h0004, 16'h0, 16'h0, 1, 0, -1, "R5 cap at half");
    step(1'b1, 4'hE, 16'h0004, 16'h0, 16'h0, 0, 0, -1, "R5 cap reached");
    step(1'b0, 4'hE, 16'h0000, 16'h0, 16'h0, 1, 0, -1, "R6 dynamic no cap");
    step(1'b1, 4'hE, 16'h0000, 16'h1, 16'h0, 0, 0, -1, "R5 still capped");
    step(1'b1, 4'hE, 16'h0000, 16'h0, 16'h0, 1, 0, -1, "R5 clipped dispatch");

    // R7 squash hits only its own thread and floors at zero
    do_reset();
    step(1'b0, 4'h0, 16'h0044, 16'h0, 16'h0,  1, 0, -1, "R7 fill t0 t1");
    step(1'b0, 4'h0, 16'h0200, 16'h0, 16'h00A0, 1, 2, -1, "R7 squash t1");
    step(1'b0, 4'h8, 16'h0000, 16'h0, 16'h0,  1, 1, -1, "R7 squash isolated");

    // R8 window full: refusal, then ascending-order grant of the one free slot
    do_reset();
    step(1'b0, 4'h0, 16'h4444, 16'h0, 16'h0, -1, 0, 0, "R8 fill a");
    step(1'b0, 4'h0, 16'h4444, 16'h0, 16'h0, -1, 0, 0, "R8 fill b");
    step(1'b0, 4'h0, 16'h4444, 16'h1, 16'h0, -1, 0, 1, "R8 full");
    step(1'b0, 4'h0, 16'h0004, 16'h0, 16'h0, -1, 0, 0, "R8 refused");
    step(1'b0, 4'h0, 16'h0000, 16'h0, 16'h0, -1, 0, 1, "R8 refill one");

    // R2 R3 R8: random traffic against the model
    do_reset();
    for (int c = 0; c < 1500; c++) begin
      bit v;
      int id;
      b_mode = ((c / 200) % 2) == 1;
      for (int t = 0; t < NT; t++) begin
        b_stall[t] = ($urandom_range(0, 3) == 0);
        b_disp[t]  = $urandom_range(0, DMAX);
        b_ret[t]   = $urandom_range(0, RMAX);
        b_sq[t]    = ($urandom_range(0, 15) == 0) ? $urandom_range(0, 12) : 0;
      end
      #1;
      model_sel(v, id);
      chk("R2 R4 random sel_vld", int'(sel_vld), int'(v));
      if (v) chk("R2 R3 random sel_tid", int'(sel_tid), id);
      chk("R8 random win_full", int'(win_full), int'(model_total() == W));
      clock_it();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule